// File: doc/BRIEF.md
# Dual-Sided Processor Messaging Unit

This block joins two processors, called side A and side B, through a pair of mirrored register banks. Each side reaches its own bank over a simple single-cycle 32-bit register bus with separate write and read strobes. A word written into one of the four outgoing slots on one side shows up in the matching incoming slot on the other side. Per-slot flags tell the sender whether its slot has been consumed and tell the receiver whether a fresh word is waiting.

Besides data words, either side can ring one of four data-less doorbells. A doorbell raises a pending flag on the far side, and software clears that flag by writing a one to it. Each side has one interrupt line. It is formed from its own flags, each of them masked by a per-event enable in that side's control word.

A message longer than four words is carried by reusing the slots in rotation, word i going through slot i mod 4. The sender waits for the slot's empty flag before each reuse, and the receiver waits for the slot's full flag. Reads of an incoming slot have side effects, so read data is returned one cycle after the read strobe.

Top module: `msg_unit`

## Requirements
- R1: After reset, the status word reads 0x00F00000 on both sides, with all four empty flags set and every other flag clear. The control word reads 0, both interrupt outputs are low, and every incoming slot reads 0.
- R2: A write to outgoing slot n (byte address 4n, n = 0..3) clears the writer's empty flag n at status bit 20+(3-n). It sets the far side's full flag n at status bit 24+(3-n), and the far side's incoming slot n (address 0x10+4n) then returns the written word. Both directions behave the same way.
- R3: Read data appears on the read-data port in the cycle after the read strobe and holds until the next read. Reading incoming slot n clears the local full flag n and sets the sending side's empty flag n.
- R4: A message of more than four words sent with word i in slot i mod 4 arrives complete and in order. Before each reuse of a slot, the sender sees that slot's empty flag set again.
- R5: Writing the control word (address 0x24) with bit 16+(3-n) set rings doorbell n. It sets the far side's pending flag n at status bit 28+(3-n) one cycle after the write. The request bit returns to 0 by itself one cycle after it was written, so it reads back as 0 afterwards.
- R6: A status write (address 0x20) clears each pending flag whose bit is written as 1 and leaves the flags written as 0 unchanged. The empty and full flags are not changed by status writes.
- R7: Each interrupt output is a registered OR of the local flags, each ANDed with its enable. The enables sit at the same bit positions as their flags in the control word: empty enable at 20+(3-n), full enable at 24+(3-n), doorbell enable at 28+(3-n). The interrupt follows the flags with one cycle of delay.
- R8: Several accesses have no effect. Control bits 15:0 read as 0 and writes to them are ignored. Writes to incoming slots are ignored. Reads of outgoing slots or unmapped addresses return 0. An access whose address bits 1:0 are not 00 selects nothing, returns 0 and leaves all flags unchanged.
- R9: When one side writes outgoing slot n in the same cycle as the far side reads incoming slot n, the read returns the previous word. Afterwards the writer's empty flag n is 0 and the reader's full flag n is 1.
- R10: When a doorbell reaches the far side in the same cycle as that side writes a 1 to clear the same pending flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Asynchronous active-low reset |
| aWrEn | input | 1 | Side A write strobe |
| aRdEn | input | 1 | Side A read strobe |
| aAddr | input | 6 | Side A byte address |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data, valid one cycle after the read strobe |
| aIrq | output | 1 | Side A interrupt |
| bWrEn | input | 1 | Side B write strobe |
| bRdEn | input | 1 | Side B read strobe |
| bAddr | input | 6 | Side B byte address |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data, valid one cycle after the read strobe |
| bIrq | output | 1 | Side B interrupt |

## Verification
Single-word exchanges in both directions on different slots show whether the slot index and the direction are routed correctly and whether each flag lands on the correct side. A ten-word stream that rotates through the slots shows ordering, and shows that each empty flag comes back before its slot is reused. Colliding accesses show which update wins: a write against a far read of the same slot, and a doorbell arrival against a clear of the same flag. A long random mix of slot writes, slot reads, control writes with enables and doorbells, and pending-flag clears on both sides is compared with a bench model after every operation. That mix includes a check of both interrupt lines.

// File: rtl/msg_unit_pkg.sv
`timescale 1ns/1ps
package msg_unit_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int NUM_CH   = 4;
  localparam int NUM_SIDE = 2;
  localparam int IDX_W    = ADDR_W - 2;

  // word indexes on the register bus
  localparam int TX_BASE  = 0;
  localparam int RX_BASE  = NUM_CH;
  localparam int STAT_IDX = 2 * NUM_CH;
  localparam int CTRL_IDX = 2 * NUM_CH + 1;

  // field positions inside status and control words
  localparam int GIR_LSB = 16;
  localparam int TE_LSB  = 20;
  localparam int RF_LSB  = 24;
  localparam int GP_LSB  = 28;

  typedef struct packed {
    logic [NUM_CH-1:0] txWr;
    logic [NUM_CH-1:0] rxRd;
    logic              statWr;
    logic              ctrlWr;
  } strobe_t;

  // channel n lives at field bit (NUM_CH-1-n)
  function automatic logic [NUM_CH-1:0] revCh(input logic [NUM_CH-1:0] v);
    logic [NUM_CH-1:0] r;
    for (int i = 0; i < NUM_CH; i++) r[NUM_CH-1-i] = v[i];
    return r;
  endfunction
endpackage

// File: rtl/msg_ctrl.sv
`timescale 1ns/1ps
module msg_ctrl
  import msg_unit_pkg::*;
(
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [NUM_SIDE-1:0]                       wrEn,
  input  logic [NUM_SIDE-1:0]                       rdEn,
  input  logic [NUM_SIDE-1:0][ADDR_W-1:0]           addr,
  input  logic [NUM_SIDE-1:0][DATA_W-1:0]           statusVal,
  input  logic [NUM_SIDE-1:0][DATA_W-1:0]           ctrlVal,
  input  logic [NUM_SIDE-1:0][NUM_CH-1:0][DATA_W-1:0] rxVal,
  output strobe_t [NUM_SIDE-1:0]                    stb,
  output logic [NUM_SIDE-1:0][DATA_W-1:0]           rdata
);
  for (genvar s = 0; s < NUM_SIDE; s++) begin : gSide
    logic [IDX_W-1:0]  idx;
    logic              aligned;
    strobe_t           sideStb;
    logic [DATA_W-1:0] rdNext;
    logic [DATA_W-1:0] rdReg;

    assign idx     = addr[s][ADDR_W-1:2];
    assign aligned = (addr[s][1:0] == 2'b00);

    always_comb begin
      sideStb = '0;
      for (int n = 0; n < NUM_CH; n++) begin
        sideStb.txWr[n] = wrEn[s] && aligned && (idx == IDX_W'(TX_BASE + n));
        sideStb.rxRd[n] = rdEn[s] && aligned && (idx == IDX_W'(RX_BASE + n));
      end
      sideStb.statWr = wrEn[s] && aligned && (idx == IDX_W'(STAT_IDX));
      sideStb.ctrlWr = wrEn[s] && aligned && (idx == IDX_W'(CTRL_IDX));
    end

    always_comb begin
      rdNext = '0;
      if (aligned) begin
        for (int n = 0; n < NUM_CH; n++)
          if (idx == IDX_W'(RX_BASE + n)) rdNext = rxVal[s][n];
        if (idx == IDX_W'(STAT_IDX)) rdNext = statusVal[s];
        if (idx == IDX_W'(CTRL_IDX)) rdNext = ctrlVal[s];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        rdReg <= '0;
      else if (rdEn[s]) rdReg <= rdNext;
    end

    assign stb[s]   = sideStb;
    assign rdata[s] = rdReg;
  end
endmodule

// File: rtl/msg_datapath.sv
`timescale 1ns/1ps
module msg_datapath
  import msg_unit_pkg::*;
(
  input  logic                                      clk,
  input  logic                                      rstN,
  input  strobe_t [NUM_SIDE-1:0]                    stb,
  input  logic [NUM_SIDE-1:0][DATA_W-1:0]           wdata,
  output logic [NUM_SIDE-1:0][DATA_W-1:0]           statusVal,
  output logic [NUM_SIDE-1:0][DATA_W-1:0]           ctrlVal,
  output logic [NUM_SIDE-1:0][NUM_CH-1:0][DATA_W-1:0] rxVal,
  output logic [NUM_SIDE-1:0]                       irq
);
  logic [NUM_SIDE-1:0][NUM_CH-1:0] te, rf, gip, gir, tie, rie, gie;
  logic [NUM_SIDE-1:0][NUM_CH-1:0][DATA_W-1:0] word;   // word[s]: sent by side s

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      te   <= '1;
      rf   <= '0;
      gip  <= '0;
      gir  <= '0;
      tie  <= '0;
      rie  <= '0;
      gie  <= '0;
      word <= '0;
      irq  <= '0;
    end else begin
      for (int s = 0; s < NUM_SIDE; s++) begin
        for (int n = 0; n < NUM_CH; n++) begin
          // own slot: a local write beats a far read in the same cycle
          if (stb[s].txWr[n]) begin
            word[s][n] <= wdata[s];
            te[s][n]   <= 1'b0;
          end else if (stb[NUM_SIDE-1-s].rxRd[n]) begin
            te[s][n] <= 1'b1;
          end
          if (stb[NUM_SIDE-1-s].txWr[n])  rf[s][n] <= 1'b1;
          else if (stb[s].rxRd[n])        rf[s][n] <= 1'b0;
          // doorbell arrival beats a same-cycle clear
          if (gir[NUM_SIDE-1-s][n])
            gip[s][n] <= 1'b1;
          else if (stb[s].statWr && wdata[s][GP_LSB + NUM_CH - 1 - n])
            gip[s][n] <= 1'b0;
        end
        gir[s] <= stb[s].ctrlWr ? revCh(wdata[s][GIR_LSB +: NUM_CH]) : '0;
        if (stb[s].ctrlWr) begin
          tie[s] <= revCh(wdata[s][TE_LSB +: NUM_CH]);
          rie[s] <= revCh(wdata[s][RF_LSB +: NUM_CH]);
          gie[s] <= revCh(wdata[s][GP_LSB +: NUM_CH]);
        end
        irq[s] <= |((te[s] & tie[s]) | (rf[s] & rie[s]) | (gip[s] & gie[s]));
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SIDE; s++) begin
      statusVal[s] = '0;
      statusVal[s][TE_LSB +: NUM_CH] = revCh(te[s]);
      statusVal[s][RF_LSB +: NUM_CH] = revCh(rf[s]);
      statusVal[s][GP_LSB +: NUM_CH] = revCh(gip[s]);
      ctrlVal[s] = '0;
      ctrlVal[s][GIR_LSB +: NUM_CH] = revCh(gir[s]);
      ctrlVal[s][TE_LSB +: NUM_CH]  = revCh(tie[s]);
      ctrlVal[s][RF_LSB +: NUM_CH]  = revCh(rie[s]);
      ctrlVal[s][GP_LSB +: NUM_CH]  = revCh(gie[s]);
      for (int n = 0; n < NUM_CH; n++) rxVal[s][n] = word[NUM_SIDE-1-s][n];
    end
  end
endmodule

// File: rtl/msg_unit.sv
`timescale 1ns/1ps
module msg_unit
  import msg_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              aWrEn,
  input  logic              aRdEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  output logic              aIrq,
  input  logic              bWrEn,
  input  logic              bRdEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata,
  output logic              bIrq
);
  logic [NUM_SIDE-1:0]                         wrEn, rdEn, irq;
  logic [NUM_SIDE-1:0][ADDR_W-1:0]             addr;
  logic [NUM_SIDE-1:0][DATA_W-1:0]             wdata, rdata, statusVal, ctrlVal;
  logic [NUM_SIDE-1:0][NUM_CH-1:0][DATA_W-1:0] rxVal;
  strobe_t [NUM_SIDE-1:0]                      stb;

  assign wrEn  = {bWrEn, aWrEn};
  assign rdEn  = {bRdEn, aRdEn};
  assign addr  = {bAddr, aAddr};
  assign wdata = {bWdata, aWdata};

  msg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .statusVal(statusVal), .ctrlVal(ctrlVal), .rxVal(rxVal),
    .stb(stb), .rdata(rdata)
  );

  msg_datapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(wdata),
    .statusVal(statusVal), .ctrlVal(ctrlVal), .rxVal(rxVal), .irq(irq)
  );

  assign aRdata = rdata[0];
  assign bRdata = rdata[1];
  assign aIrq   = irq[0];
  assign bIrq   = irq[1];
endmodule

// File: rtl/msg_unit_chk.sv
`timescale 1ns/1ps
module msg_unit_chk
  import msg_unit_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input strobe_t [NUM_SIDE-1:0]          stb,
  input logic [NUM_SIDE-1:0][DATA_W-1:0] statusVal,
  input logic [NUM_SIDE-1:0][DATA_W-1:0] ctrlVal,
  input logic                            aIrq,
  input logic                            bIrq
);
  logic [NUM_SIDE-1:0] irqVec;
  assign irqVec = {bIrq, aIrq};

  for (genvar s = 0; s < NUM_SIDE; s++) begin : gSide
    for (genvar n = 0; n < NUM_CH; n++) begin : gCh
      assert_tx_flags_R2: assert property (@(posedge clk) disable iff (!rstN)
        stb[s].txWr[n] |=> (!statusVal[s][TE_LSB + NUM_CH - 1 - n]
                            && statusVal[NUM_SIDE-1-s][RF_LSB + NUM_CH - 1 - n]));

      assert_rx_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
        (stb[s].rxRd[n] && !stb[NUM_SIDE-1-s].txWr[n]) |=>
          (!statusVal[s][RF_LSB + NUM_CH - 1 - n]
           && statusVal[NUM_SIDE-1-s][TE_LSB + NUM_CH - 1 - n]));

      assert_bell_arrive_R5: assert property (@(posedge clk) disable iff (!rstN)
        ctrlVal[s][GIR_LSB + NUM_CH - 1 - n] |=>
          statusVal[NUM_SIDE-1-s][GP_LSB + NUM_CH - 1 - n]);

      assert_bell_selfclear_R5: assert property (@(posedge clk) disable iff (!rstN)
        (ctrlVal[s][GIR_LSB + NUM_CH - 1 - n] && !stb[s].ctrlWr) |=>
          !ctrlVal[s][GIR_LSB + NUM_CH - 1 - n]);
    end

    assert_statwr_keeps_te_R6: assert property (@(posedge clk) disable iff (!rstN)
      (stb[s].statWr && !(|stb[NUM_SIDE-1-s].rxRd)) |=>
        $stable(statusVal[s][TE_LSB +: NUM_CH]));

    assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (irqVec[s] == $past(|(statusVal[s] & ctrlVal[s]))));
  end
endmodule

bind msg_unit msg_unit_chk uChk (
  .clk(clk), .rstN(rstN), .stb(stb), .statusVal(statusVal),
  .ctrlVal(ctrlVal), .aIrq(aIrq), .bIrq(bIrq)
);

// File: tb/sim_msg_unit.sv
`timescale 1ns/1ps
module sim_msg_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]       wrEn = '0, rdEn = '0;
  logic [1:0][5:0]  addr = '0;
  logic [1:0][31:0] wdata = '0;
  logic [31:0] aRdata, bRdata;
  logic aIrq, bIrq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msg_unit u0 (
    .clk(clk), .rstN(rstN),
    .aWrEn(wrEn[0]), .aRdEn(rdEn[0]), .aAddr(addr[0]), .aWdata(wdata[0]),
    .aRdata(aRdata), .aIrq(aIrq),
    .bWrEn(wrEn[1]), .bRdEn(rdEn[1]), .bAddr(addr[1]), .bWdata(wdata[1]),
    .bRdata(bRdata), .bIrq(bIrq)
  );

  // bench model
  bit [31:0] mWord [2][4];
  bit [3:0]  mTe[2], mRf[2], mGip[2], mTie[2], mRie[2], mGie[2];

  function automatic bit [3:0] rev4(bit [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction
  function automatic bit [31:0] expStatus(int s);
    return {rev4(mGip[s]), rev4(mRf[s]), rev4(mTe[s]), 20'h0};
  endfunction
  function automatic bit [31:0] expCtrl(int s);
    return {rev4(mGie[s]), rev4(mRie[s]), rev4(mTie[s]), 4'h0, 16'h0};
  endfunction
  function automatic bit expIrq(int s);
    return |((mTe[s] & mTie[s]) | (mRf[s] & mRie[s]) | (mGip[s] & mGie[s]));
  endfunction
  function automatic logic [31:0] rdOf(int s);
    return (s == 0) ? aRdata : bRdata;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one bus access on one side; returns at the negedge after the capturing edge
  task automatic busOp(int s, bit wr, logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn[s] = wr; rdEn[s] = !wr; addr[s] = a; wdata[s] = d;
    @(negedge clk);
    wrEn[s] = 0; rdEn[s] = 0;
  endtask

  task automatic txWrite(int s, int n, bit [31:0] d);
    busOp(s, 1, 6'(4 * n), d);
    mWord[s][n] = d; mTe[s][n] = 0; mRf[1-s][n] = 1;
  endtask

  task automatic rxRead(int s, int n, string req);
    busOp(s, 0, 6'(16 + 4 * n), 0);
    check(rdOf(s) === mWord[1-s][n], req, "rx data", rdOf(s), mWord[1-s][n]);
    mRf[s][n] = 0; mTe[1-s][n] = 1;
  endtask

  task automatic statRead(int s, string req);
    busOp(s, 0, 6'h20, 0);
    check(rdOf(s) === expStatus(s), req, "status", rdOf(s), expStatus(s));
  endtask

  task automatic ctrlRead(int s, string req);
    busOp(s, 0, 6'h24, 0);
    check(rdOf(s) === expCtrl(s), req, "control", rdOf(s), expCtrl(s));
  endtask

  task automatic ctrlWrite(int s, bit [31:0] v);
    busOp(s, 1, 6'h24, v);
    mTie[s] = rev4(v[23:20]); mRie[s] = rev4(v[27:24]); mGie[s] = rev4(v[31:28]);
    mGip[1-s] |= rev4(v[19:16]);
  endtask

  task automatic statClear(int s, bit [31:0] v);
    busOp(s, 1, 6'h20, v);
    mGip[s] &= ~rev4(v[31:28]);
  endtask

  task automatic checkIrq(string req);
    @(negedge clk);
    @(negedge clk);
    check(aIrq === expIrq(0), req, "side A irq", 32'(aIrq), 32'(expIrq(0)));
    check(bIrq === expIrq(1), req, "side B irq", 32'(bIrq), 32'(expIrq(1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [31:0] msg [10];
    int seed;
    for (int s = 0; s < 2; s++) begin
      mTe[s] = 4'hF; mRf[s] = 0; mGip[s] = 0; mTie[s] = 0; mRie[s] = 0; mGie[s] = 0;
      for (int n = 0; n < 4; n++) mWord[s][n] = 0;
    end
    seed = $urandom(32'h1234_5678);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check(aIrq === 1'b0 && bIrq === 1'b0, "R1", "irq after reset", {aIrq, bIrq}, 0);
    statRead(0, "R1");
    statRead(1, "R1");
    check(expStatus(0) == 32'h00F0_0000, "R1", "model reset status", expStatus(0), 32'h00F0_0000);
    ctrlRead(0, "R1");
    ctrlRead(1, "R1");
    rxRead(0, 2, "R1");

    // R2 and R3 single words in both directions
    txWrite(0, 1, 32'hA5A5_0001);
    statRead(0, "R2");
    statRead(1, "R2");
    rxRead(1, 1, "R3");
    check(bRdata === 32'hA5A5_0001, "R3", "read data held", bRdata, 32'hA5A5_0001);
    statRead(0, "R3");
    statRead(1, "R3");
    txWrite(1, 3, 32'h5A5A_0003);
    statRead(0, "R2");
    rxRead(0, 3, "R3");
    statRead(1, "R3");

    // R8 accesses without effect
    txWrite(0, 1, 32'h1111_2222);
    busOp(0, 1, 6'h14, 32'hDEAD_BEEF);          // write to incoming slot 1
    statRead(0, "R8");
    statRead(1, "R8");
    busOp(0, 0, 6'h04, 0);                      // read outgoing slot
    check(aRdata === 32'h0, "R8", "outgoing slot read", aRdata, 0);
    busOp(1, 0, 6'h30, 0);                      // unmapped
    check(bRdata === 32'h0, "R8", "unmapped read", bRdata, 0);
    busOp(1, 0, 6'h15, 0);                      // misaligned incoming slot 1
    check(bRdata === 32'h0, "R8", "misaligned read", bRdata, 0);
    statRead(1, "R8");                          // full flag 1 still set
    busOp(0, 1, 6'h05, 32'h9999_9999);          // misaligned outgoing write
    rxRead(1, 1, "R8");
    ctrlWrite(0, 32'h0000_FFFF);
    ctrlRead(0, "R8");

    // R5 and R6 doorbells
    ctrlWrite(0, 32'h1 << (16 + 3 - 2));
    statRead(1, "R5");
    ctrlRead(0, "R5");
    check(mGip[1] == 4'b0100, "R5", "model pending", 32'(mGip[1]), 32'h4);
    statClear(1, 32'h0);
    statRead(1, "R6");
    statClear(1, 32'h0FF0_0000);
    statRead(1, "R6");
    statClear(1, 32'h1 << (28 + 3 - 2));
    statRead(1, "R6");

    // R7 interrupt
    ctrlWrite(1, 32'h1 << (24 + 3));
    checkIrq("R7");
    txWrite(0, 0, 32'hCAFE_0000);
    checkIrq("R7");
    check(bIrq === 1'b1, "R7", "full-flag irq", 32'(bIrq), 1);
    rxRead(1, 0, "R7");
    checkIrq("R7");
    ctrlWrite(0, 32'h00F0_0000);
    checkIrq("R7");
    ctrlWrite(0, 32'h0);
    ctrlWrite(1, 32'h1 << 28);
    ctrlWrite(0, 32'h1 << 16);
    checkIrq("R7");
    check(bIrq === 1'b1, "R7", "doorbell irq", 32'(bIrq), 1);
    statClear(1, 32'h1 << 28);
    checkIrq("R7");

    // R4 ten-word stream A to B
    for (int i = 0; i < 10; i++) msg[i] = $urandom;
    for (int i = 0; i < 10; i++) begin
      if (i >= 4) begin
        rxRead(1, (i - 4) % 4, "R4");
        check(bRdata === msg[i-4], "R4", "stream order", bRdata, msg[i-4]);
      end
      busOp(0, 0, 6'h20, 0);
      check(aRdata[20 + 3 - (i % 4)] === 1'b1, "R4", "empty before reuse",
            32'(aRdata[20 + 3 - (i % 4)]), 1);
      txWrite(0, i % 4, msg[i]);
    end
    for (int i = 6; i < 10; i++) begin
      rxRead(1, i % 4, "R4");
      check(bRdata === msg[i], "R4", "stream tail", bRdata, msg[i]);
    end

    // R9 write against far read of the same slot
    txWrite(0, 2, 32'h0000_0A1D);
    @(negedge clk);
    wrEn[0] = 1; addr[0] = 6'h08; wdata[0] = 32'h0000_0BEE;
    rdEn[1] = 1; addr[1] = 6'h18;
    @(negedge clk);
    wrEn[0] = 0; rdEn[1] = 0;
    check(bRdata === 32'h0000_0A1D, "R9", "colliding read", bRdata, 32'h0000_0A1D);
    mWord[0][2] = 32'h0000_0BEE; mTe[0][2] = 0; mRf[1][2] = 1;
    statRead(0, "R9");
    statRead(1, "R9");
    rxRead(1, 2, "R9");

    // R10 doorbell arrival against a clear of the same flag
    @(negedge clk);
    wrEn[0] = 1; addr[0] = 6'h24; wdata[0] = 32'h1 << (16 + 3 - 1);
    @(negedge clk);
    wrEn[0] = 0;
    wrEn[1] = 1; addr[1] = 6'h20; wdata[1] = 32'h1 << (28 + 3 - 1);
    @(negedge clk);
    wrEn[1] = 0;
    mTie[0] = 0; mRie[0] = 0; mGie[0] = 0; mGip[1][1] = 1;
    statRead(1, "R10");

    // random mix, compared with the model (R2 R3 R5 R6 R7)
    for (int k = 0; k < 400; k++) begin
      int s, n, kind;
      bit [31:0] v;
      s = $urandom_range(1, 0);
      n = $urandom_range(3, 0);
      kind = $urandom_range(5, 0);
      v = $urandom;
      case (kind)
        0: txWrite(s, n, v);
        1: rxRead(s, n, "R3");
        2: statRead(s, "R2");
        3: begin ctrlWrite(s, v & 32'hFFFF_0000); ctrlRead(s, "R5"); end
        4: statClear(s, v);
        default: statRead(s, "R6");
      endcase
      checkIrq("R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule